// File: doc/BRIEF.md
# Station Management Serial Slave

This block is the device-side end of the two-wire station management link. It runs directly on the management clock driven by the station manager and samples the bidirectional data line on every rising edge. A frame that passes the preamble, start, opcode and address checks either writes a 16-bit word into a small register file or returns a word from it. On a return, the data line is driven through an output enable and a separate output value.

The address the slave answers to is not taken from pins. It is a 5-bit field inside one of its own registers, so the slave can be readdressed at run time. A capability bit in the status register lets frames begin after a single idle bit instead of the full preamble. A local read/write port gives the surrounding logic access to the same register file. Frames addressed to another device are tracked to their end, so their data bits are never taken for the start of a new frame.

Top module: `mdio_slave_top`

## Requirements
- R1: After reset the output enable is low and the local port reads register 0 as 16'h3100, register 1 as 16'h7809 and register 16 as the default address 3 placed in bits 10:6 (16'h00C0). Every other register reads zero.
- R2: A frame is accepted only after at least 32 consecutive sampled ones, followed by the start pair 0 then 1. A run of 31 ones followed by a well-formed frame gets no response.
- R3: An opcode of 1,0 is a read and 0,1 is a write. An opcode of 0,0 or 1,1 aborts the frame: nothing is driven and nothing is written.
- R4: The device address and the register address are five bits each, sent most significant bit first. A frame whose device address differs from the slave's own address drives nothing and writes nothing. Its turnaround and 16 data bits are skipped, even when the short preamble is enabled.
- R5: On a read, the output enable stays low during the first turnaround bit. It is high with the output at 0 during the second turnaround bit. It then presents data bits 15 down to 0, one per clock, each changing just after a rising edge. The enable drops right after bit 0.
- R6: On a write, the two turnaround bits are ignored. The 16 data bits, most significant first, are committed to the addressed register on the edge that samples bit 0. They are then visible on the local port.
- R7: Only register addresses 0, 1, 2, 3, 16 and 17 are implemented. The other addresses read zero on both ports and ignore writes.
- R8: When bit 6 of register 1 is set, a frame may begin after a single sampled one instead of 32. When that bit is clear, a single one is not enough.
- R9: A start pair other than 0,1 aborts the frame. The slave then needs a fresh preamble before it accepts another frame.
- R10: A local write takes effect on the clock edge where it is presented. Local read data appears one clock after the address. If a serial write and a local write hit the same register on the same edge, the serial write wins.
- R11: The slave's own address is bits 10:6 of register 16. Changing that field makes the slave answer the new address and ignore the old one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock from the station manager; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_i | input | 1 | Sampled value of the management data line |
| mdio_o | output | 1 | Value driven onto the data line while enabled |
| mdio_oe | output | 1 | Output enable for the data line driver |
| loc_addr | input | 5 | Local port register address |
| loc_wdata | input | 16 | Local port write data |
| loc_we | input | 1 | Local port write strobe |
| loc_rdata | output | 16 | Local port read data, registered |

## Verification
The bench builds the block with its default parameters: 5-bit addresses, 16-bit data, a 32-bit preamble and six implemented registers. With these values the preamble threshold is reachable as a 31-versus-32 boundary. The mix of implemented and unimplemented addresses exposes the zero-read and write-ignore paths. The address field in register 16 and the capability bit in register 1 sit at addresses the serial frames can reach, so readdressing and preamble suppression can be driven from both ports.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [3:0] {
    ST_HUNT,
    ST_STA1,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_RD,
    ST_WD,
    ST_PASS
  } mdio_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = '0,
  parameter logic [DATA_W-1:0] CTRL_RST = '0,
  parameter logic [DATA_W-1:0] STAT_RST = '0,
  parameter logic [ADDR_W-1:0] DEF_PHYAD = '0,
  parameter int ADRREG = 16,
  parameter int ADR_LSB = 6,
  parameter int CAPREG = 1,
  parameter int CAP_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic              loc_we,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic [ADDR_W-1:0] mdio_addr,
  input  logic [DATA_W-1:0] mdio_wdata,
  input  logic              mdio_we,
  output logic [DATA_W-1:0] mdio_rdata,
  output logic [ADDR_W-1:0] own_addr,
  output logic              pre_sup
);

  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [NREG];

  function automatic logic [DATA_W-1:0] rst_val(input int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == 0)      v = CTRL_RST;
    if (idx == CAPREG) v = STAT_RST;
    if (idx == ADRREG) v[ADR_LSB +: ADDR_W] = DEF_PHYAD;
    return v;
  endfunction

  // Serial write is applied last so it wins a same-edge collision
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= rst_val(i);
    end else begin
      if (loc_we && IMPL_MASK[loc_addr])   mem[loc_addr]  <= loc_wdata;
      if (mdio_we && IMPL_MASK[mdio_addr]) mem[mdio_addr] <= mdio_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) loc_rdata <= '0;
    else     loc_rdata <= IMPL_MASK[loc_addr] ? mem[loc_addr] : '0;
  end

  assign mdio_rdata = IMPL_MASK[mdio_addr] ? mem[mdio_addr] : '0;
  assign own_addr   = mem[ADRREG][ADR_LSB +: ADDR_W];
  assign pre_sup    = mem[CAPREG][CAP_BIT];

  // R6: a committed serial write is held in storage on the next edge
  a_r6_commit_lands: assert property (@(posedge clk) disable iff (rst)
    (mdio_we && IMPL_MASK[mdio_addr]) |=> (mem[$past(mdio_addr)] == $past(mdio_wdata)));

  // R7: local reads of unimplemented addresses return zero
  a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (!IMPL_MASK[loc_addr]) |=> (loc_rdata == '0));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              pre_sup,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int BCW = $clog2(DATA_W + 2);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam logic [BCW-1:0] ADR_LAST  = BCW'(ADDR_W - 1);
  localparam logic [BCW-1:0] DAT_LAST  = BCW'(DATA_W - 1);
  localparam logic [BCW-1:0] PASS_LAST = BCW'(DATA_W + 1);
  localparam logic [PCW-1:0] PRE_FULL  = PCW'(PRE_LEN);

  mdio_state_e       state;
  logic [PCW-1:0]    pre_cnt;
  logic [BCW-1:0]    bit_cnt;
  logic              op_hi;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] reg_q;
  logic [DATA_W-1:0] sh;
  logic              is_rd;
  logic [1:0]        op_nxt;
  logic              pre_ok;

  assign op_nxt = {op_hi, mdio_i};
  assign pre_ok = (pre_cnt == PRE_FULL) || (pre_sup && (pre_cnt != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      pre_cnt <= '0;
      bit_cnt <= '0;
      op_hi   <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (mdio_i) begin
            if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            pre_cnt <= '0;
            if (pre_ok) state <= ST_STA1;
          end
        end
        ST_STA1: begin
          bit_cnt <= '0;
          state   <= mdio_i ? ST_OP : ST_HUNT;
        end
        ST_OP: begin
          op_hi <= mdio_i;
          if (bit_cnt == BCW'(1)) begin
            bit_cnt <= '0;
            if (op_nxt == OPC_READ) begin
              state <= ST_PHY;
              is_rd <= 1'b1;
            end else if (op_nxt == OPC_WRITE) begin
              state <= ST_PHY;
              is_rd <= 1'b0;
            end else begin
              state <= ST_HUNT;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_PHY: begin
          phy_q <= {phy_q[ADDR_W-2:0], mdio_i};
          if (bit_cnt == ADR_LAST) begin
            bit_cnt <= '0;
            state   <= ST_REG;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_REG: begin
          reg_q <= {reg_q[ADDR_W-2:0], mdio_i};
          if (bit_cnt == ADR_LAST) begin
            bit_cnt <= '0;
            state   <= (phy_q == own_addr) ? ST_TA : ST_PASS;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_TA: begin
          if (bit_cnt == '0) begin
            bit_cnt <= BCW'(1);
            if (is_rd) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
              sh      <= rd_data;
            end
          end else begin
            bit_cnt <= '0;
            if (is_rd) begin
              state  <= ST_RD;
              mdio_o <= sh[DATA_W-1];
              sh     <= {sh[DATA_W-2:0], 1'b0};
            end else begin
              state <= ST_WD;
            end
          end
        end
        ST_RD: begin
          if (bit_cnt == DAT_LAST) begin
            bit_cnt <= '0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            state   <= ST_HUNT;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            mdio_o  <= sh[DATA_W-1];
            sh      <= {sh[DATA_W-2:0], 1'b0};
          end
        end
        ST_WD: begin
          sh <= {sh[DATA_W-2:0], mdio_i};
          if (bit_cnt == DAT_LAST) begin
            bit_cnt <= '0;
            state   <= ST_HUNT;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_PASS: begin
          if (bit_cnt == PASS_LAST) begin
            bit_cnt <= '0;
            state   <= ST_HUNT;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign reg_addr = reg_q;
  assign wr_en    = (state == ST_WD) && (bit_cnt == DAT_LAST);
  assign wr_data  = {sh[DATA_W-2:0], mdio_i};

  // R5: the enable rises only in the second turnaround slot, driving zero
  a_r5_ta_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> (!mdio_o && state == ST_TA));

  // R5: the enable is released only at the end of the data field
  a_r5_release_end: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> ($past(state) == ST_RD && state == ST_HUNT));

  // R3: the line is driven only for frames decoded as reads
  a_r3_drive_reads_only: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> is_rd);

  // R4: no drive while hunting or skipping a foreign frame
  a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT || state == ST_PASS) |-> !mdio_oe);

  // R6: a commit is preceded by a cycle already inside the data field
  a_r6_full_word: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(state) == ST_WD));

endmodule

// File: rtl/mdio_slave_top.sv
module mdio_slave_top #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 32'h0003_000F,
  parameter logic [DATA_W-1:0] CTRL_RST = 16'h3100,
  parameter logic [DATA_W-1:0] STAT_RST = 16'h7809,
  parameter logic [ADDR_W-1:0] DEF_PHYAD = 5'd3,
  parameter int ADRREG  = 16,
  parameter int ADR_LSB = 6,
  parameter int CAPREG  = 1,
  parameter int CAP_BIT = 6
) (
  input  logic              mdc,
  input  logic              rst,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic              loc_we,
  output logic [DATA_W-1:0] loc_rdata
);

  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  logic              s_we;
  logic [DATA_W-1:0] s_rdata;
  logic [ADDR_W-1:0] own_addr;
  logic              pre_sup;

  mdio_frame_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk     (mdc),
    .rst     (rst),
    .mdio_i  (mdio_i),
    .own_addr(own_addr),
    .pre_sup (pre_sup),
    .rd_data (s_rdata),
    .reg_addr(s_addr),
    .wr_en   (s_we),
    .wr_data (s_wdata),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  mdio_regfile #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IMPL_MASK(IMPL_MASK),
    .CTRL_RST (CTRL_RST),
    .STAT_RST (STAT_RST),
    .DEF_PHYAD(DEF_PHYAD),
    .ADRREG   (ADRREG),
    .ADR_LSB  (ADR_LSB),
    .CAPREG   (CAPREG),
    .CAP_BIT  (CAP_BIT)
  ) u_regs (
    .clk       (mdc),
    .rst       (rst),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_we    (loc_we),
    .loc_rdata (loc_rdata),
    .mdio_addr (s_addr),
    .mdio_wdata(s_wdata),
    .mdio_we   (s_we),
    .mdio_rdata(s_rdata),
    .own_addr  (own_addr),
    .pre_sup   (pre_sup)
  );

endmodule

// File: tb/tb_mdio_slave_top.sv
module tb_mdio_slave_top;

  localparam logic [31:0] IMPL = 32'h0003_000F;

  logic        mdc = 1'b0;
  logic        rst = 1'b1;
  logic        mbit = 1'b1;
  logic        mdio_o, mdio_oe;
  logic [4:0]  loc_addr = '0;
  logic [15:0] loc_wdata = '0;
  logic        loc_we = 1'b0;
  logic [15:0] loc_rdata;
  logic        line;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [32];

  assign line = mdio_oe ? mdio_o : mbit;

  always #4 mdc = ~mdc;

  mdio_slave_top dut (
    .mdc(mdc), .rst(rst), .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_we(loc_we), .loc_rdata(loc_rdata)
  );

  function automatic logic [4:0] own();
    return model[16][10:6];
  endfunction

  function automatic logic [15:0] expect_rd(input logic [4:0] a);
    return IMPL[a] ? model[a] : 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge mdc);
    mbit = b;
  endtask

  task automatic flush();
    bit_out(1'b0);
    bit_out(1'b0);
  endtask

  task automatic header(input int pre, input logic [1:0] st, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] ra);
    for (int i = 0; i < pre; i++) bit_out(1'b1);
    bit_out(st[1]); bit_out(st[0]);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = 4; i >= 0; i--) bit_out(phy[i]);
    for (int i = 4; i >= 0; i--) bit_out(ra[i]);
  endtask

  task automatic do_read(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra,
                         input bit resp, input logic [15:0] expv, input string req);
    logic [15:0] v;
    bit bad;
    header(pre, st, op, phy, ra);
    if (!resp) begin
      bad = 0;
      for (int i = 0; i < 19; i++) begin
        @(negedge mdc);
        mbit = 1'b1;
        if (mdio_oe) bad = 1;
      end
      chk(!bad, req, "no drive expected", 16'(bad), 16'h0);
    end else begin
      @(negedge mdc);
      mbit = 1'b1;
      chk(!mdio_oe, "R5", "enable in turnaround bit 1", 16'(mdio_oe), 16'h0);
      @(negedge mdc);
      chk(mdio_oe && !mdio_o, "R5", "turnaround bit 2 oe/o", {14'h0, mdio_oe, mdio_o}, 16'h0002);
      bad = 0;
      for (int i = 15; i >= 0; i--) begin
        @(negedge mdc);
        v[i] = mdio_o;
        if (!mdio_oe) bad = 1;
      end
      chk(!bad, "R5", "enable held over data", 16'(bad), 16'h0);
      @(negedge mdc);
      chk(!mdio_oe, "R5", "enable released after bit 0", 16'(mdio_oe), 16'h0);
      chk(v == expv, req, "read data", v, expv);
    end
  endtask

  task automatic do_write(input int pre, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] d,
                          input bit collide, input logic [15:0] cdata);
    header(pre, 2'b01, op, phy, ra);
    bit_out(1'b1); bit_out(1'b0);
    for (int i = 15; i >= 0; i--) begin
      bit_out(d[i]);
      if (collide && i == 0) begin
        loc_we = 1'b1; loc_addr = ra; loc_wdata = cdata;
      end
    end
    @(negedge mdc);
    mbit = 1'b1;
    loc_we = 1'b0;
  endtask

  task automatic loc_read(input logic [4:0] a, output logic [15:0] v);
    @(negedge mdc);
    loc_addr = a;
    @(negedge mdc);
    v = loc_rdata;
  endtask

  task automatic loc_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge mdc);
    loc_we = 1'b1; loc_addr = a; loc_wdata = d;
    @(negedge mdc);
    loc_we = 1'b0;
    if (IMPL[a]) model[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge mdc);
    fails++;
    $display("FAIL watchdog run did not complete actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [4:0]  ra, phy;
    logic [15:0] d;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 32; i++) model[i] = 16'h0;
    model[0] = 16'h3100; model[1] = 16'h7809; model[16] = 16'h00C0;

    repeat (4) @(negedge mdc);
    rst = 1'b0;

    // R1 reset state
    chk(!mdio_oe, "R1", "oe after reset", 16'(mdio_oe), 16'h0);
    loc_read(5'd0, v);  chk(v == 16'h3100, "R1", "reg0", v, 16'h3100);
    loc_read(5'd1, v);  chk(v == 16'h7809, "R1", "reg1", v, 16'h7809);
    loc_read(5'd16, v); chk(v == 16'h00C0, "R1", "reg16", v, 16'h00C0);
    loc_read(5'd17, v); chk(v == 16'h0000, "R1", "reg17", v, 16'h0000);

    // R6 serial write, visible locally; R5 read back serially
    do_write(32, 2'b01, 5'd3, 5'd2, 16'hBEEF, 0, 16'h0);
    model[2] = 16'hBEEF;
    loc_read(5'd2, v); chk(v == 16'hBEEF, "R6", "write lands", v, 16'hBEEF);
    do_read(32, 2'b01, 2'b10, 5'd3, 5'd2, 1, 16'hBEEF, "R5");

    // R7 unimplemented address
    do_write(32, 2'b01, 5'd3, 5'd5, 16'h1357, 0, 16'h0);
    loc_read(5'd5, v); chk(v == 16'h0, "R7", "unimpl write ignored", v, 16'h0);
    do_read(32, 2'b01, 2'b10, 5'd3, 5'd5, 1, 16'h0000, "R7");

    // R2 preamble of 31 rejected, 32 accepted
    flush();
    do_read(31, 2'b01, 2'b10, 5'd3, 5'd2, 0, 16'h0, "R2");
    flush();
    do_read(32, 2'b01, 2'b10, 5'd3, 5'd2, 1, 16'hBEEF, "R2");

    // R9 bad start pair
    flush();
    do_read(32, 2'b00, 2'b10, 5'd3, 5'd2, 0, 16'h0, "R9");
    do_read(32, 2'b01, 2'b10, 5'd3, 5'd0, 1, 16'h3100, "R9");

    // R3 invalid opcodes
    do_write(32, 2'b11, 5'd3, 5'd3, 16'hAAAA, 0, 16'h0);
    do_write(32, 2'b00, 5'd3, 5'd3, 16'h5555, 0, 16'h0);
    loc_read(5'd3, v); chk(v == 16'h0, "R3", "bad opcode no write", v, 16'h0);
    do_read(32, 2'b01, 2'b00, 5'd3, 5'd2, 0, 16'h0, "R3");
    do_read(32, 2'b01, 2'b11, 5'd3, 5'd2, 0, 16'h0, "R3");

    // R4 foreign address
    do_write(32, 2'b01, 5'd12, 5'd3, 16'h7777, 0, 16'h0);
    loc_read(5'd3, v); chk(v == 16'h0, "R4", "foreign write ignored", v, 16'h0);
    do_read(32, 2'b01, 2'b10, 5'd12, 5'd2, 0, 16'h0, "R4");

    // R11 readdressing through register 16
    loc_write(5'd16, {5'd0, 5'd21, 6'd0});
    do_read(32, 2'b01, 2'b10, 5'd3, 5'd2, 0, 16'h0, "R11");
    do_read(32, 2'b01, 2'b10, 5'd21, 5'd2, 1, 16'hBEEF, "R11");

    // R8 preamble suppression
    flush();
    do_read(1, 2'b01, 2'b10, 5'd21, 5'd2, 0, 16'h0, "R8");
    loc_write(5'd1, 16'h7849);
    flush();
    do_read(1, 2'b01, 2'b10, 5'd21, 5'd2, 1, 16'hBEEF, "R8");
    // R4 foreign frame skipped in full under suppression
    flush();
    do_write(1, 2'b01, 5'd9, 5'd2, 16'hA5A5, 0, 16'h0);
    do_read(0, 2'b01, 2'b10, 5'd21, 5'd2, 1, 16'hBEEF, "R4");
    loc_write(5'd1, 16'h7809);

    // R10 collision: serial write wins
    do_write(32, 2'b01, 5'd21, 5'd17, 16'h1234, 1, 16'hFFFF);
    model[17] = 16'h1234;
    loc_read(5'd17, v); chk(v == 16'h1234, "R10", "serial wins collision", v, 16'h1234);
    loc_write(5'd17, 16'h0F0F);
    loc_read(5'd17, v); chk(v == 16'h0F0F, "R10", "local write", v, 16'h0F0F);

    // random mix
    for (int k = 0; k < 60; k++) begin
      ra  = 5'($urandom % 32);
      if (ra == 5'd16 || ra == 5'd1) ra = 5'd3;
      phy = ($urandom % 4 != 0) ? own() : 5'($urandom);
      d   = 16'($urandom);
      if ($urandom % 2) begin
        do_write(32, 2'b01, phy, ra, d, 0, 16'h0);
        if (phy == own() && IMPL[ra]) model[ra] = d;
        loc_read(ra, v);
        chk(v == expect_rd(ra), "R6", "random write", v, expect_rd(ra));
      end else begin
        do_read(32, 2'b01, 2'b10, phy, ra, phy == own(), expect_rd(ra), "R4");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule